// File: doc/BRIEF.md
# Coprocessor Host Halt Controller

This block sits between a host processor and one coprocessor core. Through a small register port the host can hold the core in reset, stop it, load a new start address and let it run again. A halt can come from three places: a host register write, a dedicated halt input pin, or the core itself executing its stop instruction. Once a halt is requested, the core is stalled. The block then waits for the core's outstanding memory accesses to finish and for a configurable number of quiet cycles. Only after that does it report the halted status and stop driving the shared memory address bus, which hands the bus to the host.

While the core is halted, the host may read and write the start-address register. When the host clears the halt latch, the core resumes. A one-cycle load strobe then tells the core to fetch from that address. The same strobe fires when the host releases the reset latch. Entry into the halted state can raise an interrupt to the host. The interrupt stays asserted until the host acknowledges it, and an enable bit can suppress it, for example when the host caused the halt itself.

Top module: `chc_top`

## Requirements
- R1: After reset, `core_rst_o`, `halt_stat_o`, `core_stall_o` and `host_irq_o` are 0, `bus_oe_o` is 1, and `pc_load_o` equals the parameter RESET_PC (default 0x100).
- R2: Any of these sets the halt latch: a write of 1 in bit 0 at offset 1, a cycle with `halt_req_i` high, or a cycle with `core_halt_insn_i` high. `core_stall_o` goes high one cycle after the latch is set.
- R3: While draining, `halt_stat_o` stays 0 and `bus_oe_o` stays 1 as long as `inflight_i` is nonzero. `halt_stat_o` rises on the FLUSH_CYC+1-th clock edge (default 3) after `inflight_i` reads zero.
- R4: While halted, `bus_oe_o` is 0 and `core_stall_o` is 1. A read at offset 1 returns the halted status in bit 0 and the halt latch in bit 1.
- R5: The start-address register at offset 2 is written only while halted. While the core is not halted, a write there is ignored and a read returns 0.
- R6: Writing 0 to bit 0 at offset 1 while halted returns the core to running on the next clock edge. At that point `bus_oe_o` returns to 1 and `pc_load_stb_o` pulses for one cycle with `pc_load_o` holding the written address.
- R7: Writing 1 to bit 0 at offset 0 drives `core_rst_o` high, and a read at offset 0 returns it. Writing 0 releases it, and `pc_load_stb_o` pulses for one cycle in the same cycle the reset output drops.
- R8: If enable bit 0 at offset 3 is set, entering the halted state raises `host_irq_o`. It stays high until a write at offset 3 with bit 1 set. A read at offset 3 returns the pending flag in bit 1.
- R9: With bit 0 at offset 3 cleared, entering the halted state leaves `host_irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 2 | Host register offset |
| reg_wdata_i | input | DATA_W | Host write data |
| reg_rdata_o | output | DATA_W | Host read data (combinational on offset) |
| halt_req_i | input | 1 | Host halt request pin |
| halt_stat_o | output | 1 | Core is halted and bus is released |
| host_irq_o | output | 1 | Halt interrupt to host |
| core_rst_o | output | 1 | Reset to the core |
| core_stall_o | output | 1 | Stall request to the core |
| core_halt_insn_i | input | 1 | Core executed its stop instruction |
| inflight_i | input | CNT_W | Outstanding core memory accesses |
| pc_load_o | output | DATA_W | Start address for the core |
| pc_load_stb_o | output | 1 | One-cycle start-address load strobe |
| bus_oe_o | output | 1 | Core address bus output enable |

## Verification
A drain state stuck or left too early shows up on `halt_stat_o` and `bus_oe_o`. The exact edge count after `inflight_i` reaches zero pins it to the cycle. A wrong start-address register or missing write lock appears on `pc_load_o` right away and on the read port. A lost or mistimed resume appears as a missing `pc_load_stb_o` pulse on the cycle after the release write. Interrupt enable and acknowledge faults are visible on `host_irq_o` within a cycle of the halt entry or the acknowledge write.

// File: rtl/chc_pkg.sv
package chc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2
  } core_st_e;

  localparam logic [1:0] A_RST  = 2'd0;
  localparam logic [1:0] A_HALT = 2'd1;
  localparam logic [1:0] A_PC   = 2'd2;
  localparam logic [1:0] A_IRQ  = 2'd3;
endpackage

// File: rtl/chc_drain_fsm.sv
module chc_drain_fsm
  import chc_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int FLUSH_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_lat_i,
  input  logic [CNT_W-1:0] inflight_i,
  output core_st_e         st_o,
  output logic             enter_halt_o,
  output logic             resume_o
);
  core_st_e st_q, st_d;
  logic     drained;
  logic     resume_q;

  generate
    if (FLUSH_CYC == 0) begin : g_nowait
      assign drained = (inflight_i == '0);
    end else begin : g_wait
      localparam int FC_W = $clog2(FLUSH_CYC + 2);
      localparam logic [FC_W-1:0] FC_MAX = FC_W'(FLUSH_CYC);
      logic [FC_W-1:0] cnt_q;
      // quiet-cycle counter, restarts on any outstanding access
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (st_q != ST_DRAIN || inflight_i != '0) cnt_q <= '0;
        else if (cnt_q != FC_MAX) cnt_q <= cnt_q + 1'b1;
      end
      assign drained = (inflight_i == '0) && (cnt_q == FC_MAX);
    end
  endgenerate

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:   if (halt_lat_i) st_d = ST_DRAIN;
      ST_DRAIN: if (drained) st_d = ST_HALT;
      ST_HALT:  if (!halt_lat_i) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_RUN;
      resume_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      resume_q <= (st_q == ST_HALT) && !halt_lat_i;
    end
  end

  assign st_o         = st_q;
  assign enter_halt_o = (st_q == ST_DRAIN) && drained;
  assign resume_o     = resume_q;

  // R3
  drain_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HALT && $past(st_q) == ST_DRAIN) |-> $past(inflight_i) == '0);
  // R2
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !halt_lat_i) |=> st_q == ST_RUN);
endmodule

// File: rtl/chc_host_regs.sv
module chc_host_regs
  import chc_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              halt_pin_i,
  input  logic              halt_insn_i,
  input  logic              halted_i,
  input  logic              enter_halt_i,
  output logic              halt_lat_o,
  output logic              core_rst_o,
  output logic              rel_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              irq_o
);
  logic wr_rst, wr_halt, wr_pc, wr_irq;
  logic rst_q, rel_q, halt_q, irq_en_q, irq_q;
  logic [DATA_W-1:0] pc_q;

  assign wr_rst  = we_i && addr_i == A_RST;
  assign wr_halt = we_i && addr_i == A_HALT;
  assign wr_pc   = we_i && addr_i == A_PC;
  assign wr_irq  = we_i && addr_i == A_IRQ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q    <= 1'b0;
      rel_q    <= 1'b0;
      halt_q   <= 1'b0;
      irq_en_q <= 1'b0;
      irq_q    <= 1'b0;
      pc_q     <= DATA_W'(RESET_PC);
    end else begin
      if (wr_rst) rst_q <= wdata_i[0];
      rel_q <= wr_rst && !wdata_i[0] && rst_q;
      // hardware halt sources win over a host clear
      if (halt_pin_i || halt_insn_i) halt_q <= 1'b1;
      else if (wr_halt)              halt_q <= wdata_i[0];
      if (wr_pc && halted_i) pc_q <= wdata_i;
      if (wr_irq) irq_en_q <= wdata_i[0];
      if (enter_halt_i && irq_en_q)  irq_q <= 1'b1;
      else if (wr_irq && wdata_i[1]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_RST:   rdata_o = DATA_W'(rst_q);
      A_HALT:  rdata_o = DATA_W'({halt_q, halted_i});
      A_PC:    rdata_o = halted_i ? pc_q : '0;
      default: rdata_o = DATA_W'({irq_q, irq_en_q});
    endcase
  end

  assign halt_lat_o = halt_q;
  assign core_rst_o = rst_q;
  assign rel_o      = rel_q;
  assign pc_o       = pc_q;
  assign irq_o      = irq_q;

  // R5
  pc_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_i |=> $stable(pc_q));
  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !(wr_irq && wdata_i[1])) |=> irq_q);
endmodule

// File: rtl/chc_top.sv
module chc_top
  import chc_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 4,
  parameter int          FLUSH_CYC = 2,
  parameter logic [31:0] RESET_PC  = 32'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              halt_req_i,
  output logic              halt_stat_o,
  output logic              host_irq_o,
  output logic              core_rst_o,
  output logic              core_stall_o,
  input  logic              core_halt_insn_i,
  input  logic [CNT_W-1:0]  inflight_i,
  output logic [DATA_W-1:0] pc_load_o,
  output logic              pc_load_stb_o,
  output logic              bus_oe_o
);
  core_st_e st;
  logic halt_lat, enter_halt, resume, rel;

  chc_drain_fsm #(.CNT_W(CNT_W), .FLUSH_CYC(FLUSH_CYC)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_lat_i   (halt_lat),
    .inflight_i   (inflight_i),
    .st_o         (st),
    .enter_halt_o (enter_halt),
    .resume_o     (resume)
  );

  chc_host_regs #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .halt_pin_i   (halt_req_i),
    .halt_insn_i  (core_halt_insn_i),
    .halted_i     (st == ST_HALT),
    .enter_halt_i (enter_halt),
    .halt_lat_o   (halt_lat),
    .core_rst_o   (core_rst_o),
    .rel_o        (rel),
    .pc_o         (pc_load_o),
    .irq_o        (host_irq_o)
  );

  assign halt_stat_o   = (st == ST_HALT);
  assign core_stall_o  = (st != ST_RUN);
  assign bus_oe_o      = (st != ST_HALT);
  assign pc_load_stb_o = resume || rel;

  // R7
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> pc_load_stb_o);
  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_irq_o) |-> $rose(halt_stat_o));
  // R6
  resume_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_load_stb_o && !core_rst_o && !$past(core_rst_o)) |-> $past(halt_stat_o));
endmodule

// File: tb/chc_top_test.sv
`timescale 1ns/1ps
module chc_top_test;
  localparam int DW = 32;
  localparam int CW = 4;
  localparam int FC = 2;

  logic clk = 0, rst_n = 0;
  logic we = 0, hreq = 0, hinsn = 0;
  logic [1:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic [CW-1:0] infl = 0;
  logic [DW-1:0] rdata, pc;
  logic hstat, irq, crst, stall, stb, oe;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  chc_top #(.DATA_W(DW), .CNT_W(CW), .FLUSH_CYC(FC), .RESET_PC(32'h100)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .halt_req_i(hreq),
    .halt_stat_o(hstat), .host_irq_o(irq), .core_rst_o(crst),
    .core_stall_o(stall), .core_halt_insn_i(hinsn), .inflight_i(infl),
    .pc_load_o(pc), .pc_load_stb_o(stb), .bus_oe_o(oe));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_halt(output int n);
    n = 0;
    while (!hstat && n < 40) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    chk(!crst && !hstat && !stall && !irq, "R1 ctrl", {crst, hstat, stall, irq}, 0);
    chk(oe, "R1 oe", oe, 1);
    chk(pc == 32'h100, "R1 pc", pc, 32'h100);
  endtask

  task automatic t_pc_running;
    logic [31:0] d;
    wr(2'd2, 32'h55);
    chk(pc == 32'h100, "R5 write ignored", pc, 32'h100);
    rd(2'd2, d);
    chk(d == 0, "R5 read zero", d, 0);
  endtask

  task automatic t_host_halt;
    logic [31:0] d;
    int n;
    wr(2'd3, 32'h1);
    infl = 3;
    wr(2'd1, 32'h1);
    @(negedge clk);
    chk(stall, "R2 stall after latch", stall, 1);
    repeat (8) @(negedge clk);
    chk(!hstat && oe, "R3 hold while busy", {hstat, oe}, 32'h1);
    infl = 0;
    wait_halt(n);
    chk(n == FC + 1, "R3 quiet edges", n, FC + 1);
    chk(!oe && stall, "R4 bus released", {oe, stall}, 32'h1);
    rd(2'd1, d);
    chk(d == 3, "R4 status read", d, 3);
    chk(irq, "R8 irq raised", irq, 1);
    repeat (3) @(negedge clk);
    chk(irq, "R8 irq held", irq, 1);
    rd(2'd3, d);
    chk(d == 3, "R8 pending read", d, 3);
    wr(2'd3, 32'h3);
    chk(!irq, "R8 ack", irq, 0);
  endtask

  task automatic t_resume;
    logic [31:0] d;
    wr(2'd2, 32'h2000);
    rd(2'd2, d);
    chk(d == 32'h2000, "R5 halted read", d, 32'h2000);
    wr(2'd1, 32'h0);
    chk(hstat, "R6 still halted at write edge", hstat, 1);
    @(negedge clk);
    chk(!hstat && oe && stb, "R6 resume", {hstat, oe, stb}, 32'h3);
    chk(pc == 32'h2000, "R6 pc", pc, 32'h2000);
    @(negedge clk);
    chk(!stb && !stall, "R6 single strobe", {stb, stall}, 0);
  endtask

  task automatic t_insn_halt;
    logic [31:0] d;
    int n;
    wr(2'd3, 32'h0);
    @(negedge clk); hinsn = 1;
    @(negedge clk); hinsn = 0;
    wait_halt(n);
    chk(hstat, "R2 insn halt", hstat, 1);
    chk(!irq, "R9 no irq", irq, 0);
    rd(2'd3, d);
    chk(d == 0, "R9 pending clear", d, 0);
    wr(2'd1, 32'h0);
    @(negedge clk);
    chk(!hstat, "R6 release", hstat, 0);
  endtask

  task automatic t_pin_halt;
    int n;
    @(negedge clk); hreq = 1;
    @(negedge clk); hreq = 0;
    wait_halt(n);
    chk(hstat && !oe, "R2 pin halt", {hstat, oe}, 32'h2);
    wr(2'd1, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_rst_latch;
    logic [31:0] d;
    wr(2'd0, 32'h1);
    chk(crst && !stb, "R7 reset held", {crst, stb}, 32'h2);
    rd(2'd0, d);
    chk(d == 1, "R7 read", d, 1);
    wr(2'd0, 32'h0);
    chk(!crst && stb, "R7 release strobe", {crst, stb}, 32'h1);
    @(negedge clk);
    chk(!stb, "R7 single strobe", stb, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pc_running();
    t_host_halt();
    t_resume();
    t_insn_halt();
    t_pin_halt();
    t_rst_latch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule